// File: doc/BRIEF.md
# Interrupt and Exception Nesting Controller

This block owns a core's privilege register (PR) and instruction pointer (IP) and manages the nesting of three kinds of handler entry: hardware interrupts, normal exceptions and double exceptions. Each kind has its own shadow pair. On entry, the interrupted IP and PR are saved into that pair, PR rises to all ones (full privilege), and IP loads the handler address supplied on an input port. Two return strobes bring the saved context back: one for hardware interrupts and one for exceptions.

Escalation follows the nesting depth. A fault raised while a normal exception handler has not yet returned becomes a double exception. A fault inside the double-exception handler is a triple fault, which stops the core for good. When other cores share the system, the core first raises a one-cycle broadcast. When the core runs alone, it stops at once. While no event is being taken, running code may load new IP and PR values through a context-write strobe.

Top module: `irq_nest_ctl`

## Requirements
- R1: After reset, PR is all ones, IP equals the RESET_IP parameter, and irq_masked_o, halted_o and broadcast_o are all 0.
- R2: A hardware interrupt taken in the base context saves the current IP and PR, loads IP from hw_vec_i, sets PR to all ones and masks further interrupts. A hardware interrupt while masked has no effect. hw_ret_i restores the saved IP and PR and unmasks.
- R3: An exception outside any exception handler saves IP and PR, loads IP from exc_vec_i and sets PR to all ones. Until that handler returns, hardware interrupts are held off.
- R4: exc_ret_i inside a normal exception handler restores IP and PR from the exception pair and returns to the context that was interrupted.
- R5: An exception inside a normal exception handler is taken as a double exception. IP loads dexc_vec_i, PR becomes all ones, and the handler's IP and PR go into the double pair while the exception pair stays intact.
- R6: exc_ret_i inside the double-exception handler restores IP and PR from the double pair and resumes the normal exception handler.
- R7: An exception inside the double handler with single_core_i = 0 raises broadcast_o for exactly one cycle. halted_o rises in the next cycle.
- R8: The same fault with single_core_i = 1 raises halted_o at once, and broadcast_o never rises.
- R9: Once broadcasting or halted, every input event is ignored and IP and PR hold until reset.
- R10: An exception wins over a hardware interrupt and over a return strobe that arrive in the same cycle.
- R11: With no event taken, ctx_wr_i loads IP from ctx_ip_i and PR from ctx_pr_i.
- R12: An exception during a hardware interrupt handler is a normal exception. Its return restores the interrupt handler's context, with interrupts still masked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| single_core_i | input | 1 | 1 when no other core is active |
| hw_irq_i | input | 1 | Hardware interrupt request |
| hw_vec_i | input | IP_W | Hardware interrupt handler address |
| hw_ret_i | input | 1 | Return from hardware interrupt handler |
| exc_i | input | 1 | Exception raised this cycle |
| exc_vec_i | input | IP_W | Normal exception handler address |
| dexc_vec_i | input | IP_W | Double exception handler address |
| exc_ret_i | input | 1 | Return from exception handler |
| ctx_wr_i | input | 1 | Load IP and PR from running code |
| ctx_ip_i | input | IP_W | IP value for ctx_wr_i |
| ctx_pr_i | input | PR_W | PR value for ctx_wr_i |
| pr_o | output | PR_W | Current privilege register |
| ip_o | output | IP_W | Current instruction pointer |
| irq_masked_o | output | 1 | Hardware interrupts currently held off |
| broadcast_o | output | 1 | Triple-fault broadcast pulse |
| halted_o | output | 1 | Core shut down |

## Verification
The assertions assume that every strobe is a single-cycle level sampled at the rising edge, and that single_core_i is steady while a triple fault is being taken. The stimulus changes inputs only on falling edges and clears each strobe after one cycle. single_core_i is set before the fault sequence begins and is left alone until the next reset. Return strobes are sent both in valid contexts and in contexts where they should do nothing.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_EXC   = 3'd1,
        ST_DEXC  = 3'd2,
        ST_BCAST = 3'd3,
        ST_HALT  = 3'd4
    } nest_state_e;

    typedef enum logic [3:0] {
        ACT_NONE       = 4'd0,
        ACT_CTX_WR     = 4'd1,
        ACT_HW_ENTER   = 4'd2,
        ACT_HW_RET     = 4'd3,
        ACT_EXC_ENTER  = 4'd4,
        ACT_EXC_RET    = 4'd5,
        ACT_DEXC_ENTER = 4'd6,
        ACT_DEXC_RET   = 4'd7,
        ACT_TRIPLE     = 4'd8
    } nest_act_e;

    localparam int unsigned NUM_SLOTS = 3;
    localparam int unsigned SLOT_HW   = 0;
    localparam int unsigned SLOT_EXC  = 1;
    localparam int unsigned SLOT_DEXC = 2;

endpackage

// File: rtl/irq_nest_arb.sv
module irq_nest_arb
    import irq_nest_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  nest_state_e state_i,
    input  logic        hw_active_i,
    input  logic        exc_i,
    input  logic        exc_ret_i,
    input  logic        hw_ret_i,
    input  logic        hw_irq_i,
    input  logic        ctx_wr_i,
    output nest_act_e   act_o
);

    always_comb begin
        act_o = ACT_NONE;
        unique case (state_i)
            ST_RUN: begin
                if (exc_i)                          act_o = ACT_EXC_ENTER;
                else if (hw_ret_i && hw_active_i)   act_o = ACT_HW_RET;
                else if (hw_irq_i && !hw_active_i)  act_o = ACT_HW_ENTER;
                else if (ctx_wr_i)                  act_o = ACT_CTX_WR;
            end
            ST_EXC: begin
                if (exc_i)          act_o = ACT_DEXC_ENTER;
                else if (exc_ret_i) act_o = ACT_EXC_RET;
                else if (ctx_wr_i)  act_o = ACT_CTX_WR;
            end
            ST_DEXC: begin
                if (exc_i)          act_o = ACT_TRIPLE;
                else if (exc_ret_i) act_o = ACT_DEXC_RET;
                else if (ctx_wr_i)  act_o = ACT_CTX_WR;
            end
            default: act_o = ACT_NONE;
        endcase
    end

    // R3: no interrupt entry while any exception handler is open
    p_no_hw_in_handler_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i != ST_RUN) |-> (act_o != ACT_HW_ENTER));

    // R10: a live exception always selects an exception-class action
    p_exc_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_i && (state_i == ST_RUN || state_i == ST_EXC || state_i == ST_DEXC))
        |-> (act_o == ACT_EXC_ENTER || act_o == ACT_DEXC_ENTER || act_o == ACT_TRIPLE));

    // R9: nothing is acted on after a triple fault
    p_dead_ignores_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_BCAST || state_i == ST_HALT) |-> (act_o == ACT_NONE));

endmodule

// File: rtl/irq_shadow_pair.sv
module irq_shadow_pair #(
    parameter int unsigned PR_W = 8,
    parameter int unsigned IP_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            save_i,
    input  logic [PR_W-1:0] pr_i,
    input  logic [IP_W-1:0] ip_i,
    output logic [PR_W-1:0] pr_o,
    output logic [IP_W-1:0] ip_o
);

    typedef struct packed {
        logic [PR_W-1:0] pr;
        logic [IP_W-1:0] ip;
    } pair_t;

    pair_t pair_d, pair_q;

    always_comb begin
        pair_d = pair_q;
        if (save_i) begin
            pair_d.pr = pr_i;
            pair_d.ip = ip_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pair_q <= '0;
        else        pair_q <= pair_d;
    end

    assign pr_o = pair_q.pr;
    assign ip_o = pair_q.ip;

    // R5: a pair not being saved keeps its content
    p_hold_unless_saved_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !save_i |=> ($stable(ip_o) && $stable(pr_o)));

endmodule

// File: rtl/irq_nest_ctl.sv
module irq_nest_ctl
    import irq_nest_pkg::*;
#(
    parameter int unsigned PR_W     = 8,
    parameter int unsigned IP_W     = 16,
    parameter int unsigned RESET_IP = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            single_core_i,
    input  logic            hw_irq_i,
    input  logic [IP_W-1:0] hw_vec_i,
    input  logic            hw_ret_i,
    input  logic            exc_i,
    input  logic [IP_W-1:0] exc_vec_i,
    input  logic [IP_W-1:0] dexc_vec_i,
    input  logic            exc_ret_i,
    input  logic            ctx_wr_i,
    input  logic [IP_W-1:0] ctx_ip_i,
    input  logic [PR_W-1:0] ctx_pr_i,
    output logic [PR_W-1:0] pr_o,
    output logic [IP_W-1:0] ip_o,
    output logic            irq_masked_o,
    output logic            broadcast_o,
    output logic            halted_o
);

    localparam logic [PR_W-1:0] PR_FULL  = '1;
    localparam logic [IP_W-1:0] IP_RESET = IP_W'(RESET_IP);

    typedef struct packed {
        nest_state_e     st;
        logic            hw_act;
        logic [PR_W-1:0] pr;
        logic [IP_W-1:0] ip;
    } core_ctx_t;

    core_ctx_t ctx_d, ctx_q;
    nest_act_e act;

    logic [NUM_SLOTS-1:0] slot_save;
    logic [PR_W-1:0]      slot_pr [NUM_SLOTS];
    logic [IP_W-1:0]      slot_ip [NUM_SLOTS];

    irq_nest_arb u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .state_i     (ctx_q.st),
        .hw_active_i (ctx_q.hw_act),
        .exc_i       (exc_i),
        .exc_ret_i   (exc_ret_i),
        .hw_ret_i    (hw_ret_i),
        .hw_irq_i    (hw_irq_i),
        .ctx_wr_i    (ctx_wr_i),
        .act_o       (act)
    );

    always_comb begin
        slot_save            = '0;
        slot_save[SLOT_HW]   = (act == ACT_HW_ENTER);
        slot_save[SLOT_EXC]  = (act == ACT_EXC_ENTER);
        slot_save[SLOT_DEXC] = (act == ACT_DEXC_ENTER);
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        irq_shadow_pair #(
            .PR_W (PR_W),
            .IP_W (IP_W)
        ) u_pair (
            .clk    (clk),
            .rst_n  (rst_n),
            .save_i (slot_save[g]),
            .pr_i   (ctx_q.pr),
            .ip_i   (ctx_q.ip),
            .pr_o   (slot_pr[g]),
            .ip_o   (slot_ip[g])
        );
    end

    always_comb begin
        ctx_d = ctx_q;
        unique case (act)
            ACT_CTX_WR: begin
                ctx_d.pr = ctx_pr_i;
                ctx_d.ip = ctx_ip_i;
            end
            ACT_HW_ENTER: begin
                ctx_d.pr     = PR_FULL;
                ctx_d.ip     = hw_vec_i;
                ctx_d.hw_act = 1'b1;
            end
            ACT_HW_RET: begin
                ctx_d.pr     = slot_pr[SLOT_HW];
                ctx_d.ip     = slot_ip[SLOT_HW];
                ctx_d.hw_act = 1'b0;
            end
            ACT_EXC_ENTER: begin
                ctx_d.pr = PR_FULL;
                ctx_d.ip = exc_vec_i;
                ctx_d.st = ST_EXC;
            end
            ACT_EXC_RET: begin
                ctx_d.pr = slot_pr[SLOT_EXC];
                ctx_d.ip = slot_ip[SLOT_EXC];
                ctx_d.st = ST_RUN;
            end
            ACT_DEXC_ENTER: begin
                ctx_d.pr = PR_FULL;
                ctx_d.ip = dexc_vec_i;
                ctx_d.st = ST_DEXC;
            end
            ACT_DEXC_RET: begin
                ctx_d.pr = slot_pr[SLOT_DEXC];
                ctx_d.ip = slot_ip[SLOT_DEXC];
                ctx_d.st = ST_EXC;
            end
            ACT_TRIPLE: begin
                ctx_d.st = single_core_i ? ST_HALT : ST_BCAST;
            end
            default: ;
        endcase
        if (ctx_q.st == ST_BCAST) ctx_d.st = ST_HALT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q.st     <= ST_RUN;
            ctx_q.hw_act <= 1'b0;
            ctx_q.pr     <= PR_FULL;
            ctx_q.ip     <= IP_RESET;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign pr_o         = ctx_q.pr;
    assign ip_o         = ctx_q.ip;
    assign irq_masked_o = ctx_q.hw_act || (ctx_q.st != ST_RUN);
    assign broadcast_o  = (ctx_q.st == ST_BCAST);
    assign halted_o     = (ctx_q.st == ST_HALT);

    // R2: every handler entry lands at full privilege
    p_entry_full_priv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_HW_ENTER || act == ACT_EXC_ENTER || act == ACT_DEXC_ENTER)
        |=> (pr_o == PR_FULL));

    // R4: exception return takes IP from the exception pair
    p_exc_ret_restore_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_EXC_RET) |=> (ip_o == $past(slot_ip[SLOT_EXC])));

    // R7: broadcast lasts one cycle and is followed by halt
    p_bcast_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        broadcast_o |=> (!broadcast_o && halted_o));

    // R8: a lone core halts without broadcasting
    p_single_no_bcast_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_TRIPLE && single_core_i) |=> (halted_o && !broadcast_o));

    // R9: halt persists and freezes IP and PR
    p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |=> (halted_o && $stable(ip_o) && $stable(pr_o)));

endmodule

// File: tb/irq_nest_ctl_tb_top.sv
`timescale 1ns/1ps
module irq_nest_ctl_tb_top;

    localparam int unsigned PR_W = 4;
    localparam int unsigned IP_W = 8;
    localparam int unsigned RST_IP = 8'h10;
    localparam logic [IP_W-1:0] EV = 8'hE0;
    localparam logic [IP_W-1:0] DV = 8'hD0;
    localparam logic [PR_W-1:0] FULL = 4'hF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic single_core = 1'b0;
    logic hw_irq = 1'b0, hw_ret = 1'b0, exc = 1'b0, exc_ret = 1'b0, ctx_wr = 1'b0;
    logic [IP_W-1:0] hw_vec = '0, ctx_ip = '0;
    logic [PR_W-1:0] ctx_pr = '0;
    logic [PR_W-1:0] pr;
    logic [IP_W-1:0] ip;
    logic masked, bcast, halted;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_nest_ctl #(.PR_W(PR_W), .IP_W(IP_W), .RESET_IP(RST_IP)) dut_i (
        .clk(clk), .rst_n(rst_n), .single_core_i(single_core),
        .hw_irq_i(hw_irq), .hw_vec_i(hw_vec), .hw_ret_i(hw_ret),
        .exc_i(exc), .exc_vec_i(EV), .dexc_vec_i(DV), .exc_ret_i(exc_ret),
        .ctx_wr_i(ctx_wr), .ctx_ip_i(ctx_ip), .ctx_pr_i(ctx_pr),
        .pr_o(pr), .ip_o(ip), .irq_masked_o(masked),
        .broadcast_o(bcast), .halted_o(halted)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        hw_irq = 0; hw_ret = 0; exc = 0; exc_ret = 0; ctx_wr = 0;
    endtask

    task automatic do_ctx(input logic [IP_W-1:0] i, input logic [PR_W-1:0] p);
        ctx_wr = 1; ctx_ip = i; ctx_pr = p; tick();
    endtask
    task automatic do_hw(input logic [IP_W-1:0] v);
        hw_irq = 1; hw_vec = v; tick();
    endtask
    task automatic do_hwret();  hw_ret = 1;  tick(); endtask
    task automatic do_exc();    exc = 1;     tick(); endtask
    task automatic do_ret();    exc_ret = 1; tick(); endtask

    task automatic do_reset();
        rst_n = 0; tick(); tick(); rst_n = 1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk("R1 pr", pr, FULL);
        chk("R1 ip", ip, RST_IP);
        chk("R1 masked", masked, 0);
        chk("R1 halted", halted, 0);
        chk("R1 bcast", bcast, 0);

        // R11 context write
        do_ctx(8'h20, 4'h3);
        chk("R11 ip", ip, 8'h20);
        chk("R11 pr", pr, 4'h3);

        // R2 sweep of interrupt entry, masked request, return
        for (int i = 0; i < 8; i++) begin
            do_ctx(8'(i * 5 + 1), 4'(i));
            do_hw(8'(8'h80 + i));
            chk("R2 entry ip", ip, 8'h80 + i);
            chk("R2 entry pr", pr, FULL);
            chk("R2 masked", masked, 1);
            do_hw(8'h99);
            chk("R2 masked irq ignored", ip, 8'h80 + i);
            do_hwret();
            chk("R2 ret ip", ip, i * 5 + 1);
            chk("R2 ret pr", pr, i);
            chk("R2 unmasked", masked, 0);
        end

        // R10 exception and interrupt together; R3 held off; R4 return
        for (int p = 0; p < 4; p++) begin
            do_ctx(8'(8'h30 + p), 4'(p));
            exc = 1; hw_irq = 1; hw_vec = 8'h77; tick();
            chk("R10 exc beats irq ip", ip, EV);
            chk("R3 entry pr", pr, FULL);
            chk("R3 masked", masked, 1);
            do_hw(8'h66);
            chk("R3 irq held off", ip, EV);
            do_ret();
            chk("R4 ret ip", ip, 8'h30 + p);
            chk("R4 ret pr", pr, p);
            chk("R4 unmasked", masked, 0);
            do_hw(8'h90);
            chk("R4 pending-free irq taken", ip, 8'h90);
            do_hwret();
        end

        // R5 double exception and R6 return to exception handler
        do_ctx(8'h11, 4'h1);
        do_exc();
        do_ctx(8'h41, 4'h2);
        do_exc();
        chk("R5 dexc ip", ip, DV);
        chk("R5 dexc pr", pr, FULL);
        do_ret();
        chk("R6 ret ip", ip, 8'h41);
        chk("R6 ret pr", pr, 4'h2);
        chk("R6 still masked", masked, 1);
        do_ret();
        chk("R5 exc pair intact ip", ip, 8'h11);
        chk("R5 exc pair intact pr", pr, 4'h1);

        // R10 exception beats return
        do_exc();
        exc = 1; exc_ret = 1; tick();
        chk("R10 exc beats ret", ip, DV);
        do_ret(); do_ret();
        chk("R10 recovered ip", ip, 8'h11);

        // R12 exception inside interrupt handler
        do_hw(8'h88);
        do_ctx(8'h55, 4'h5);
        do_exc();
        chk("R12 normal exc ip", ip, EV);
        do_ret();
        chk("R12 ret ip", ip, 8'h55);
        chk("R12 ret pr", pr, 4'h5);
        chk("R12 still masked", masked, 1);
        do_hwret();
        chk("R12 base ip", ip, 8'h11);
        chk("R12 unmasked", masked, 0);

        // R7 multicore triple fault, R9 ignore afterwards
        single_core = 0;
        do_exc(); do_exc(); do_exc();
        chk("R7 bcast", bcast, 1);
        chk("R7 not yet halted", halted, 0);
        chk("R9 ip held in bcast", ip, DV);
        tick();
        chk("R7 bcast dropped", bcast, 0);
        chk("R7 halted", halted, 1);
        do_hw(8'h12); do_exc(); do_ret(); do_hwret(); do_ctx(8'h33, 4'h3);
        chk("R9 ip frozen", ip, DV);
        chk("R9 pr frozen", pr, FULL);
        chk("R9 still halted", halted, 1);
        chk("R9 no bcast", bcast, 0);

        // R8 single core triple fault
        do_reset();
        single_core = 1;
        do_exc(); do_exc(); do_exc();
        chk("R8 halted at once", halted, 1);
        chk("R8 no bcast", bcast, 0);
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R8 bcast stays low", bcast, 0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule